// File: doc/BRIEF.md
# Keyed Watchdog Timer with Prescaler

This block is a 64-bit up-counter behind a small register port. It can serve as a general timer or as a watchdog. A programmable prescaler sets how often the count advances. The 64-bit count is compared against a 64-bit period, and the count returns to zero when it matches. Software places the block in watchdog mode and arms it by writing an arming key to the watchdog control word with the enable bit set. From then on it must keep feeding the block. Each feed is the arming key followed by a service key, and the service key clears the count.

If a count match happens while the watchdog is enabled in watchdog mode, the block drives a single-cycle reset request and sets a sticky timeout flag. Once the watchdog is enabled, all configuration registers are frozen until a block reset, and so are the counter and period halves. The register port is a plain control interface. A write takes effect on the clock edge that samples `reg_wr`. Read data is registered and appears one cycle after `reg_rd`. The port has no back-pressure.

Top module: `wdt_timer64`

## Requirements
- R1: After reset every register reads zero, `reg_rdata` is zero and `wdt_reset_req` is low.
- R2: The count advances only while both release bits (global control bits 1:0) equal 3 and the run field (counter control bits 23:22) equals 2. With a run field of 0 the count holds its value. With both release bits at zero the count is forced to zero.
- R3: A divide field value v in global control bits 15:8 advances the count once every v+1 clocks.
- R4: Carries from the low half (word address 2) propagate into the high half (word address 3), so together they form one 64-bit count.
- R5: A read of the low half returns the live low half and also captures the high half. A read of the high half returns the captured copy, which keeps a 64-bit read consistent.
- R6: Writing key 0xA5C6 in watchdog control bits 31:16 (word address 6) with bit 14 set enables the watchdog, and bit 14 then reads back as 1.
- R7: Key 0xDA7E clears the count and the prescaler only when it is the next control-word write after 0xA5C6. Any other key, or 0xDA7E without a preceding 0xA5C6, returns the key sequence to idle and leaves the count alone.
- R8: Once the watchdog is enabled, bit 14 cannot be cleared, and writes to global control, counter control, the counter halves and the period halves (word addresses 4 and 5) are ignored.
- R9: With mode field (global control bits 3:2) equal to 2 and the watchdog enabled, a prescaler tick that finds the count equal to the period causes three effects. The count returns to zero, `wdt_reset_req` goes high for exactly one cycle, and the timeout flag at watchdog control bit 15 is set and stays set. With divide value v, starting from a service, the pulse follows (period+1)*(v+1) clocks after the service write.
- R10: If a service completes on the very edge where a count match would fire, the clear takes priority and no reset request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| wdt_reset_req | output | 1 | One-cycle reset request on watchdog expiry |

## Verification
A service completion and a count match can fall on the same clock edge. The bench provokes this by timing the service writes so that the service key lands on the exact edge where the match would fire, with the prescaler set to divide-by-one. It then judges three things. The request must stay low in that cycle. The following expiry must arrive a full (period+1) clocks later, which shows that the count was cleared rather than wrapped. Random key sequences are also checked against a bench model of the key state, which predicts each clear.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_GCTL   = 3'd0,
    RA_CCTL   = 3'd1,
    RA_CNT_LO = 3'd2,
    RA_CNT_HI = 3'd3,
    RA_PRD_LO = 3'd4,
    RA_PRD_HI = 3'd5,
    RA_WDCTL  = 3'd6
  } reg_addr_e;

  localparam logic [15:0] KEY_ARM = 16'hA5C6;
  localparam logic [15:0] KEY_SVC = 16'hDA7E;
  localparam logic [1:0]  MODE_WDOG = 2'd2;
  localparam logic [1:0]  RUN_CONT  = 2'd2;

  localparam int GC_MODE_LSB = 2;
  localparam int GC_DIV_LSB  = 8;
  localparam int CC_RUN_LSB  = 22;
  localparam int WD_EN_BIT   = 14;
  localparam int WD_TO_BIT   = 15;
  localparam int WD_KEY_LSB  = 16;

  typedef enum logic {KS_IDLE, KS_ARMED} key_state_e;
endpackage

// File: rtl/wdt_prescaler.sv
`timescale 1ns/1ps
module wdt_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] psc_q;

  assign tick_o = run_i && !clr_i && (psc_q == div_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                psc_q <= '0;
    else if (clr_i || !run_i)  psc_q <= '0;
    else if (psc_q == div_i)   psc_q <= '0;
    else                       psc_q <= psc_q + 1'b1;
  end
endmodule

// File: rtl/wdt_count64.sv
`timescale 1ns/1ps
module wdt_count64 #(
  parameter int HALF_W = 32,
  localparam int CW = 2 * HALF_W,
  localparam int NH = CW / HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_zero_i,
  input  logic              clr_i,
  input  logic [NH-1:0]     wr_half_i,
  input  logic [HALF_W-1:0] wdata_i,
  input  logic              tick_i,
  input  logic [CW-1:0]     period_i,
  output logic [CW-1:0]     cnt_o,
  output logic              wrap_o
);
  logic [CW-1:0] cnt_q, cnt_d, cnt_inc;

  assign cnt_inc = cnt_q + 1'b1;
  assign wrap_o  = tick_i && (cnt_q == period_i);
  assign cnt_o   = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (hold_zero_i || clr_i) begin
      cnt_d = '0;
    end else if (|wr_half_i) begin
      for (int h = 0; h < NH; h++)
        if (wr_half_i[h]) cnt_d[h*HALF_W +: HALF_W] = wdata_i;
    end else if (wrap_o) begin
      cnt_d = '0;
    end else if (tick_i) begin
      cnt_d = cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdt_keyseq.sv
`timescale 1ns/1ps
module wdt_keyseq
  import wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_i,
  input  logic [15:0] key_i,
  input  logic        en_bit_i,
  output logic        wd_en_o,
  output logic        svc_o
);
  key_state_e st_q;
  logic       en_q;

  assign wd_en_o = en_q;
  assign svc_o   = wr_i && (key_i == KEY_SVC) && (st_q == KS_ARMED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= KS_IDLE;
      en_q <= 1'b0;
    end else if (wr_i) begin
      if (key_i == KEY_ARM && (en_bit_i || en_q)) begin
        st_q <= KS_ARMED;
        en_q <= 1'b1;
      end else begin
        st_q <= KS_IDLE;
      end
    end
  end
endmodule

// File: rtl/wdt_timer64.sv
`timescale 1ns/1ps
module wdt_timer64
  import wdt_pkg::*;
#(
  parameter int PSC_W  = 8,
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              wdt_reset_req
);
  localparam int CW = 2 * HALF_W;

  logic [1:0]       rel_q, mode_q, run_sel_q;
  logic [PSC_W-1:0] div_q;
  logic [CW-1:0]    prd_q, cnt;
  logic [HALF_W-1:0] shadow_q;
  logic [REG_W-1:0] rdata_q;
  logic             req_q, timeout_q;
  logic             wd_en, svc_clear, tick, wrap, expire;
  logic             wr_cfg, hold_zero, run, cnt_wr_any;
  logic [1:0]       wr_half;

  assign wr_cfg     = reg_wr && !wd_en;
  assign hold_zero  = (rel_q == 2'b00);
  assign run        = (rel_q == 2'b11) && (run_sel_q == RUN_CONT);
  assign wr_half[0] = wr_cfg && (reg_addr == RA_CNT_LO);
  assign wr_half[1] = wr_cfg && (reg_addr == RA_CNT_HI);
  assign cnt_wr_any = |wr_half;
  assign expire     = wrap && wd_en && (mode_q == MODE_WDOG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_q     <= '0;
      mode_q    <= '0;
      div_q     <= '0;
      run_sel_q <= '0;
      prd_q     <= '0;
    end else if (wr_cfg) begin
      case (reg_addr)
        RA_GCTL: begin
          rel_q  <= reg_wdata[1:0];
          mode_q <= reg_wdata[GC_MODE_LSB +: 2];
          div_q  <= reg_wdata[GC_DIV_LSB +: PSC_W];
        end
        RA_CCTL:   run_sel_q <= reg_wdata[CC_RUN_LSB +: 2];
        RA_PRD_LO: prd_q[0 +: HALF_W] <= reg_wdata[HALF_W-1:0];
        RA_PRD_HI: prd_q[HALF_W +: HALF_W] <= reg_wdata[HALF_W-1:0];
        default: ;
      endcase
    end
  end

  wdt_prescaler #(.DIV_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run_i(run), .clr_i(svc_clear),
    .div_i(div_q), .tick_o(tick)
  );

  wdt_count64 #(.HALF_W(HALF_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .hold_zero_i(hold_zero), .clr_i(svc_clear),
    .wr_half_i(wr_half), .wdata_i(reg_wdata[HALF_W-1:0]), .tick_i(tick),
    .period_i(prd_q), .cnt_o(cnt), .wrap_o(wrap)
  );

  wdt_keyseq u_key (
    .clk(clk), .rst_n(rst_n),
    .wr_i(reg_wr && (reg_addr == RA_WDCTL)),
    .key_i(reg_wdata[WD_KEY_LSB +: 16]),
    .en_bit_i(reg_wdata[WD_EN_BIT]),
    .wd_en_o(wd_en), .svc_o(svc_clear)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q     <= 1'b0;
      timeout_q <= 1'b0;
    end else begin
      req_q     <= expire;
      timeout_q <= timeout_q | expire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      shadow_q <= '0;
    end else if (reg_rd) begin
      rdata_q <= '0;
      case (reg_addr)
        RA_GCTL: begin
          rdata_q[1:0]                 <= rel_q;
          rdata_q[GC_MODE_LSB +: 2]    <= mode_q;
          rdata_q[GC_DIV_LSB +: PSC_W] <= div_q;
        end
        RA_CCTL:   rdata_q[CC_RUN_LSB +: 2] <= run_sel_q;
        RA_CNT_LO: begin
          rdata_q[HALF_W-1:0] <= cnt[0 +: HALF_W];
          shadow_q            <= cnt[HALF_W +: HALF_W];
        end
        RA_CNT_HI: rdata_q[HALF_W-1:0] <= shadow_q;
        RA_PRD_LO: rdata_q[HALF_W-1:0] <= prd_q[0 +: HALF_W];
        RA_PRD_HI: rdata_q[HALF_W-1:0] <= prd_q[HALF_W +: HALF_W];
        RA_WDCTL: begin
          rdata_q[WD_EN_BIT] <= wd_en;
          rdata_q[WD_TO_BIT] <= timeout_q;
        end
        default: ;
      endcase
    end
  end

  assign reg_rdata     = rdata_q;
  assign wdt_reset_req = req_q;
endmodule

// File: rtl/wdt_timer64_chk.sv
`timescale 1ns/1ps
module wdt_timer64_chk #(
  parameter int CW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          hold_zero,
  input logic          svc,
  input logic          cnt_wr,
  input logic [CW-1:0] cnt,
  input logic          wd_en,
  input logic          timeout,
  input logic          reset_req
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !hold_zero && !svc && !cnt_wr) |=> $stable(cnt));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    svc |=> (cnt == '0));

  p_en_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wd_en |=> wd_en);

  p_req_wraps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> (cnt == '0) && wd_en && timeout);

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> timeout);

  p_svc_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    svc |=> !reset_req);
endmodule

bind wdt_timer64 wdt_timer64_chk #(.CW(2*HALF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .hold_zero(hold_zero),
  .svc(svc_clear), .cnt_wr(cnt_wr_any), .cnt(cnt), .wd_en(wd_en),
  .timeout(timeout_q), .reset_req(wdt_reset_req)
);

// File: tb/wdt_timer64_bench.sv
`timescale 1ns/1ps
module wdt_timer64_bench;
  import wdt_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        wdt_reset_req;

  int total = 0, bad = 0, cyc = 0, pulses = 0, last_edge = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && wdt_reset_req) pulses++;

  wdt_timer64 u_wdt_timer64 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wdt_reset_req(wdt_reset_req)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    last_edge = cyc;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
    last_edge = cyc;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(output int n);
    n = 0;
    while (n < 5000) begin
      @(negedge clk);
      n++;
      if (wdt_reset_req) break;
    end
  endtask

  function automatic int expiry_clocks(input int prd, input int v);
    return (prd + 1) * (v + 1);
  endfunction

  function automatic logic [31:0] gctl_word(input logic [1:0] rel, input logic [1:0] mode, input int v);
    return {16'h0, v[7:0], 4'h0, mode, rel};
  endfunction

  initial begin
    logic [31:0] a, b, v32;
    int n, p0, m, dv, clr_edge, sel;
    bit armed;
    logic [15:0] key;
    void'($urandom(32'd2024));
    idle(3);
    rst_n = 1'b1;
    idle(1);

    rd(RA_GCTL, a);  chk(a == 0, "R1 gctl", a, 0);
    rd(RA_WDCTL, a); chk(a == 0, "R1 wdctl", a, 0);
    rd(RA_CNT_LO, a); chk(a == 0, "R1 cnt", a, 0);
    chk(wdt_reset_req == 0, "R1 req", wdt_reset_req, 0);

    wr(RA_PRD_LO, 32'hFFFF_FFFF); wr(RA_PRD_HI, 32'hFFFF_FFFF);
    wr(RA_GCTL, gctl_word(2'b11, 2'b00, 0));
    wr(RA_CCTL, 32'(2) << 22);
    idle(2);
    rd(RA_CNT_LO, a); idle(10); rd(RA_CNT_LO, b);
    chk(b - a == 11, "R2 runs", b - a, 11);
    wr(RA_CCTL, 0);
    rd(RA_CNT_LO, a); idle(7); rd(RA_CNT_LO, b);
    chk(b == a, "R2 stopped holds", b, a);

    for (int it = 0; it < 4; it++) begin
      dv = 1 + int'($urandom % 7);
      m  = 2 + int'($urandom % 8);
      wr(RA_GCTL, gctl_word(2'b11, 2'b00, dv));
      wr(RA_CCTL, 32'(2) << 22);
      idle(3);
      rd(RA_CNT_LO, a); idle(m * (dv + 1) - 1); rd(RA_CNT_LO, b);
      chk(b - a == 32'(m), "R3 prescale", b - a, m);
      wr(RA_CCTL, 0);
    end

    wr(RA_GCTL, gctl_word(2'b00, 2'b00, 0)); idle(1);
    rd(RA_CNT_LO, a); chk(a == 0, "R2 release zero", a, 0);

    wr(RA_GCTL, gctl_word(2'b11, 2'b00, 0));
    wr(RA_CNT_LO, 32'hFFFF_FFF0); wr(RA_CNT_HI, 32'h5);
    wr(RA_CCTL, 32'(2) << 22); idle(30); wr(RA_CCTL, 0);
    rd(RA_CNT_LO, a); rd(RA_CNT_HI, b);
    chk(b == 6, "R4 carry hi", b, 6);
    chk(a > 0 && a < 64, "R4 lo wrapped", a, 32);
    wr(RA_CNT_HI, 32'h9);
    rd(RA_CNT_HI, b); chk(b == 6, "R5 hi latched", b, 6);
    rd(RA_CNT_LO, a); rd(RA_CNT_HI, b); chk(b == 9, "R5 relatch", b, 9);

    wr(RA_CNT_LO, 0); wr(RA_CNT_HI, 0);
    wr(RA_PRD_LO, 300); wr(RA_PRD_HI, 0);
    wr(RA_GCTL, gctl_word(2'b11, MODE_WDOG, 0));
    wr(RA_CCTL, 32'(2) << 22);
    wr(RA_WDCTL, {KEY_ARM, 16'h4000});
    rd(RA_WDCTL, a); chk(a[14] == 1, "R6 enabled", a, 32'h4000);
    wr(RA_WDCTL, {KEY_SVC, 16'h4000});
    measure(n); chk(n == expiry_clocks(300, 0), "R9 expiry time", n, expiry_clocks(300, 0));
    idle(1); chk(wdt_reset_req == 0, "R9 one cycle", wdt_reset_req, 0);
    rd(RA_WDCTL, a); chk(a[15] == 1, "R9 timeout flag", a, 32'hC000);

    wr(RA_GCTL, 0); rd(RA_GCTL, a);
    chk(a == gctl_word(2'b11, MODE_WDOG, 0), "R8 gctl locked", a, gctl_word(2'b11, MODE_WDOG, 0));
    wr(RA_PRD_LO, 5); rd(RA_PRD_LO, a); chk(a == 300, "R8 period locked", a, 300);
    wr(RA_WDCTL, 32'h0); rd(RA_WDCTL, a); chk(a[14] == 1, "R8 enable sticky", a, 32'hC000);
    wr(RA_CNT_LO, 32'h1234);

    p0 = pulses;
    for (int it = 0; it < 30; it++) begin
      wr(RA_WDCTL, {KEY_ARM, 16'h0});
      wr(RA_WDCTL, {KEY_SVC, 16'h0});
      clr_edge = last_edge; armed = 0;
      for (int j = 0; j < 3; j++) begin
        sel = int'($urandom % 3);
        if (sel == 0) key = KEY_ARM;
        else if (sel == 1) key = KEY_SVC;
        else begin
          key = 16'($urandom);
          if (key == KEY_ARM || key == KEY_SVC) key = key ^ 16'h1;
        end
        wr(RA_WDCTL, {key, 16'h0});
        if (key == KEY_ARM) armed = 1;
        else if (key == KEY_SVC && armed) begin clr_edge = last_edge; armed = 0; end
        else armed = 0;
        rd(RA_CNT_LO, a);
        chk(a == 32'(last_edge - 1 - clr_edge), "R7 key sequence", a, last_edge - 1 - clr_edge);
      end
    end
    chk(pulses == p0, "R7 no expiry while fed", pulses, p0);

    wr(RA_WDCTL, {KEY_ARM, 16'h0});
    wr(RA_WDCTL, {KEY_SVC, 16'h0});
    idle(299);
    wr(RA_WDCTL, {KEY_ARM, 16'h0});
    wr(RA_WDCTL, {KEY_SVC, 16'h0});
    chk(wdt_reset_req == 0, "R10 service wins", wdt_reset_req, 0);
    measure(n); chk(n == expiry_clocks(300, 0), "R10 full period after", n, expiry_clocks(300, 0));

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule